// File: doc/BRIEF.md
# Serial DAC Input Register Controller

This block is the digital front end of a 12-bit serial voltage DAC. A host writes it over a three-wire link: an active-low frame select, a serial clock and serial data. The block runs on its own system clock and oversamples all three wires through synchronizer stages. It finds the edges of the frame select and the serial clock in the system clock domain.

A write frame is 16 bits long and is sent most significant bit first. Each bit is taken on a falling edge of the serial clock. When the 16th bit arrives, the power-mode field and the code field take effect together, and the block raises a one-cycle update strobe. A frame that is cut short changes nothing. A power-down command keeps the stored code, so the previous level returns when the part is brought back to normal operation. The analog section reads the code, the mode and the termination flags.

Top module: `dacfe_top`

## Requirements
- R1: While reset is asserted and after it is released, the code output is 0, the mode is normal (00), all power-down and termination flags are 0 and the strobe is 0. These values hold until the first complete frame.
- R2: A frame starts only on a high-to-low transition of sync_n. Bits are taken on falling sclk edges, most significant first. Frame bits 15 and 14 have no effect on any output.
- R3: On the 16th falling sclk edge of a frame, the mode field (frame bits 13:12) and, in normal mode, the code field (frame bits 11:0) are loaded together. The update strobe is high for exactly one clock cycle.
- R4: If sync_n rises before the 16th falling edge, the code, the mode and the flags keep their values and no strobe is raised. A later frame is decoded from its own bits only.
- R5: Falling sclk edges after the 16th, while sync_n stays low, are ignored. A further frame needs sync_n to go high and then low again.
- R6: Mode 00 is normal and sets no flags. Mode 01 sets power_down and pull_1k. Mode 10 sets power_down and pull_100k. Mode 11 sets power_down and out_hiz. At most one termination flag is high at any time.
- R7: A frame whose mode field is not 00 leaves the stored code unchanged, so the code from before power-down is still presented when the part wakes.
- R8: Outputs change SYNC_STAGES+1 system clock cycles after the system clock cycle in which the 16th falling sclk edge is driven on the pins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_n | input | 1 | Active-low frame select from the host |
| sclk | input | 1 | Serial clock from the host; data is taken on its falling edge |
| sdin | input | 1 | Serial data from the host |
| dac_code | output | CODE_W | Code currently applied to the converter |
| pwr_mode | output | 2 | Current power mode (00 normal, 01/10/11 power-down) |
| update | output | 1 | One-cycle strobe when a complete frame commits |
| power_down | output | 1 | High in any power-down mode |
| pull_1k | output | 1 | Output terminated with the strong pulldown |
| pull_100k | output | 1 | Output terminated with the weak pulldown |
| out_hiz | output | 1 | Output left at high impedance |

## Verification
The assertions check four properties on every cycle. The code and the mode change only on a strobe cycle. The strobe never lasts two cycles. A power-down commit never alters the code. The termination flags are one-hot exactly when power-down is active. Only the bench scenarios can show the frame-level behaviour: frames aborted after different bit counts, extra clock edges after the 16th, a second burst of edges without a fresh sync_n fall, ignored top bits, and the exact cycle of each update. These scenarios are checked against a reference model that holds its pending commits in a queue.

// File: rtl/dacfe_pkg.sv
package dacfe_pkg;
  typedef enum logic [1:0] {
    PM_ON      = 2'b00,
    PM_PD_1K   = 2'b01,
    PM_PD_100K = 2'b10,
    PM_PD_HIZ  = 2'b11
  } pmode_e;

  typedef enum logic [1:0] {
    FR_IDLE  = 2'b00,
    FR_SHIFT = 2'b01,
    FR_HOLD  = 2'b10
  } frst_e;
endpackage

// File: rtl/dacfe_insync.sv
module dacfe_insync #(
  parameter int          W       = 3,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] q,
  output logic [W-1:0] q_prev
);
  localparam int DEPTH = STAGES + 1;

  logic [DEPTH-1:0][W-1:0] pipe_q;
  logic [DEPTH-1:0][W-1:0] pipe_d;

  always_comb begin
    pipe_d = {pipe_q[DEPTH-2:0], d_async};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= {DEPTH{RST_VAL}};
    else        pipe_q <= pipe_d;
  end

  assign q      = pipe_q[STAGES-1];
  assign q_prev = pipe_q[STAGES];
endmodule

// File: rtl/dacfe_frame_rx.sv
module dacfe_frame_rx
  import dacfe_pkg::*;
#(
  parameter int FRAME_BITS = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  sync_n,
  input  logic                  sync_n_d,
  input  logic                  sclk,
  input  logic                  sclk_d,
  input  logic                  sdat,
  output logic                  commit,
  output logic [FRAME_BITS-1:0] word
);
  localparam int               CNT_W = $clog2(FRAME_BITS);
  localparam logic [CNT_W-1:0] LAST  = CNT_W'(FRAME_BITS - 1);

  frst_e                 st_q, st_d;
  logic [CNT_W-1:0]      cnt_q, cnt_d;
  logic [FRAME_BITS-1:0] sh_q, sh_d;
  logic                  sync_fall, sclk_fall;
  logic [FRAME_BITS-1:0] sh_in;

  assign sync_fall = sync_n_d & ~sync_n;
  assign sclk_fall = sclk_d & ~sclk;
  assign sh_in     = {sh_q[FRAME_BITS-2:0], sdat};

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    sh_d   = sh_q;
    commit = 1'b0;
    word   = sh_in;
    unique case (st_q)
      FR_IDLE: begin
        if (sync_fall) begin
          st_d  = FR_SHIFT;
          cnt_d = '0;
          sh_d  = '0;
        end
      end
      FR_SHIFT: begin
        if (sync_n) begin
          st_d  = FR_IDLE;
          cnt_d = '0;
          sh_d  = '0;
        end else if (sclk_fall) begin
          sh_d = sh_in;
          if (cnt_q == LAST) begin
            commit = 1'b1;
            st_d   = FR_HOLD;
            cnt_d  = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      FR_HOLD: begin
        if (sync_n) st_d = FR_IDLE;
      end
      default: st_d = FR_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= FR_IDLE;
      cnt_q <= '0;
      sh_q  <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      sh_q  <= sh_d;
    end
  end
endmodule

// File: rtl/dacfe_regs.sv
module dacfe_regs
  import dacfe_pkg::*;
#(
  parameter int FRAME_BITS = 16,
  parameter int CODE_W     = 12
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  commit,
  input  logic [FRAME_BITS-1:0] word,
  output logic [CODE_W-1:0]     dac_code,
  output logic [1:0]            pwr_mode,
  output logic                  update,
  output logic                  power_down,
  output logic                  pull_1k,
  output logic                  pull_100k,
  output logic                  out_hiz
);
  localparam int MODE_LSB = CODE_W;

  logic [CODE_W-1:0] code_q, code_d;
  pmode_e            mode_q, mode_d, mode_in;
  logic              upd_q, upd_d;

  assign mode_in = pmode_e'(word[MODE_LSB+1:MODE_LSB]);

  always_comb begin
    code_d = code_q;
    mode_d = mode_q;
    upd_d  = commit;
    if (commit) begin
      mode_d = mode_in;
      if (mode_in == PM_ON) code_d = word[CODE_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
      mode_q <= PM_ON;
      upd_q  <= 1'b0;
    end else begin
      code_q <= code_d;
      mode_q <= mode_d;
      upd_q  <= upd_d;
    end
  end

  always_comb begin
    power_down = 1'b1;
    pull_1k    = 1'b0;
    pull_100k  = 1'b0;
    out_hiz    = 1'b0;
    unique case (mode_q)
      PM_ON:      power_down = 1'b0;
      PM_PD_1K:   pull_1k    = 1'b1;
      PM_PD_100K: pull_100k  = 1'b1;
      PM_PD_HIZ:  out_hiz    = 1'b1;
      default:    power_down = 1'b1;
    endcase
  end

  assign dac_code = code_q;
  assign pwr_mode = mode_q;
  assign update   = upd_q;
endmodule

// File: rtl/dacfe_top.sv
module dacfe_top #(
  parameter int FRAME_BITS  = 16,
  parameter int CODE_W      = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sync_n,
  input  logic              sclk,
  input  logic              sdin,
  output logic [CODE_W-1:0] dac_code,
  output logic [1:0]        pwr_mode,
  output logic              update,
  output logic              power_down,
  output logic              pull_1k,
  output logic              pull_100k,
  output logic              out_hiz
);
  localparam int          PIN_W   = 3;
  localparam logic [2:0]  PIN_IDLE = 3'b110;

  logic [PIN_W-1:0]      pins_s, pins_p;
  logic                  commit;
  logic [FRAME_BITS-1:0] word;

  dacfe_insync #(
    .W(PIN_W), .STAGES(SYNC_STAGES), .RST_VAL(PIN_IDLE)
  ) insync_i (
    .clk(clk), .rst_n(rst_n),
    .d_async({sync_n, sclk, sdin}),
    .q(pins_s), .q_prev(pins_p)
  );

  dacfe_frame_rx #(.FRAME_BITS(FRAME_BITS)) rx_i (
    .clk(clk), .rst_n(rst_n),
    .sync_n(pins_s[2]), .sync_n_d(pins_p[2]),
    .sclk(pins_s[1]), .sclk_d(pins_p[1]),
    .sdat(pins_s[0]),
    .commit(commit), .word(word)
  );

  dacfe_regs #(.FRAME_BITS(FRAME_BITS), .CODE_W(CODE_W)) regs_i (
    .clk(clk), .rst_n(rst_n),
    .commit(commit), .word(word),
    .dac_code(dac_code), .pwr_mode(pwr_mode), .update(update),
    .power_down(power_down), .pull_1k(pull_1k),
    .pull_100k(pull_100k), .out_hiz(out_hiz)
  );
endmodule

// File: rtl/dacfe_checker.sv
module dacfe_checker #(
  parameter int CODE_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic [CODE_W-1:0] dac_code,
  input logic [1:0]        pwr_mode,
  input logic              update,
  input logic              power_down,
  input logic              pull_1k,
  input logic              pull_100k,
  input logic              out_hiz
);
  a_r3_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    update |=> !update);

  a_r4_code_moves_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (dac_code != $past(dac_code)) |-> update);

  a_r4_mode_moves_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_mode != $past(pwr_mode)) |-> update);

  a_r7_pd_keeps_code: assert property (@(posedge clk) disable iff (!rst_n)
    (update && pwr_mode != 2'b00) |-> (dac_code == $past(dac_code)));

  a_r6_term_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    power_down |-> ($countones({pull_1k, pull_100k, out_hiz}) == 1));

  a_r6_no_term_when_on: assert property (@(posedge clk) disable iff (!rst_n)
    !power_down |-> !(pull_1k || pull_100k || out_hiz));
endmodule

bind dacfe_top dacfe_checker #(.CODE_W(CODE_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .dac_code(dac_code), .pwr_mode(pwr_mode),
  .update(update), .power_down(power_down), .pull_1k(pull_1k),
  .pull_100k(pull_100k), .out_hiz(out_hiz)
);

// File: tb/dacfe_top_tb_top.sv
module dacfe_top_tb_top;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int CODE_W = 12;
  localparam int SYNC_STAGES = 2;
  localparam int LAT = SYNC_STAGES + 1;
  localparam int HALF = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sync_n = 1'b1;
  logic sclk = 1'b1;
  logic sdin = 1'b0;
  logic [CODE_W-1:0] dac_code;
  logic [1:0] pwr_mode;
  logic update, power_down, pull_1k, pull_100k, out_hiz;

  int cyc = 0;
  int n_checks = 0;
  int n_fail = 0;
  bit running = 1'b0;
  bit done = 1'b0;

  logic [11:0] m_code = '0;
  logic [1:0]  m_mode = '0;
  int          due_q[$];
  logic [13:0] val_q[$];

  dacfe_top #(.CODE_W(CODE_W), .SYNC_STAGES(SYNC_STAGES)) dut_i (
    .clk(clk), .rst_n(rst_n), .sync_n(sync_n), .sclk(sclk), .sdin(sdin),
    .dac_code(dac_code), .pwr_mode(pwr_mode), .update(update),
    .power_down(power_down), .pull_1k(pull_1k), .pull_100k(pull_100k),
    .out_hiz(out_hiz)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  function automatic logic [3:0] flags_of(input logic [1:0] m);
    case (m)
      2'b00:   return 4'b0000;
      2'b01:   return 4'b1100;
      2'b10:   return 4'b1010;
      default: return 4'b1001;
    endcase
  endfunction

  // Reference model, compared on every clock once reset is released
  always @(negedge clk) begin
    if (running) begin
      logic exp_upd;
      exp_upd = 1'b0;
      if (due_q.size() > 0 && due_q[0] == cyc) begin
        logic [13:0] v;
        v = val_q.pop_front();
        void'(due_q.pop_front());
        exp_upd = 1'b1;
        m_mode = v[13:12];
        if (v[13:12] == 2'b00) m_code = v[11:0];
      end
      chk("R3/R7", "dac_code", dac_code, m_code);
      chk("R6", "pwr_mode", pwr_mode, m_mode);
      chk("R3/R8", "update", update, exp_upd);
      chk("R6", "flags", {power_down, pull_1k, pull_100k, out_hiz}, flags_of(m_mode));
    end
  end

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Drive one frame: nedges falling sclk edges; commit expected at the 16th when exp_commit
  task automatic frame(input logic [15:0] w, input int nedges, input bit raise, input bit exp_commit);
    sync_n = 1'b0;
    wait_n(HALF);
    for (int i = 0; i < nedges; i++) begin
      sdin = (i < 16) ? w[15-i] : ~sdin;
      wait_n(HALF);
      sclk = 1'b0;
      if (i == 15 && exp_commit) begin
        due_q.push_back(cyc + LAT);
        val_q.push_back(w[13:0]);
      end
      wait_n(HALF);
      sclk = 1'b1;
    end
    if (raise) begin
      wait_n(HALF);
      sync_n = 1'b1;
      wait_n(HALF + LAT + 1);
    end
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    wait_n(3);
    chk("R1", "code in reset", dac_code, 0);
    chk("R1", "mode in reset", pwr_mode, 0);
    chk("R1", "strobe in reset", update, 0);
    chk("R1", "flags in reset", {power_down, pull_1k, pull_100k, out_hiz}, 0);
    rst_n = 1'b1;
    running = 1'b1;
    wait_n(10);
    chk("R1", "code held after reset", dac_code, 0);

    // R2: top bits ignored, MSB first
    frame(16'hCABC, 16, 1, 1);
    chk("R2", "code with top bits set", dac_code, 12'hABC);
    frame(16'h0123, 16, 1, 1);
    chk("R3", "code after normal frame", dac_code, 12'h123);

    // R4: aborted frames
    frame(16'h0FFF, 9, 1, 0);
    chk("R4", "code after 9-edge abort", dac_code, 12'h123);
    frame(16'h3000, 15, 1, 0);
    chk("R4", "mode after 15-edge abort", pwr_mode, 0);
    frame(16'h0000, 0, 1, 0);
    frame(16'h0555, 16, 1, 1);
    chk("R4", "clean frame after abort", dac_code, 12'h555);

    // R6/R7: power-down modes keep the code
    frame(16'h1FFF, 16, 1, 1);
    chk("R6", "pull_1k in mode 01", pull_1k, 1);
    chk("R7", "code kept in mode 01", dac_code, 12'h555);
    frame(16'h2AAA, 16, 1, 1);
    chk("R6", "pull_100k in mode 10", pull_100k, 1);
    frame(16'h3001, 16, 1, 1);
    chk("R6", "out_hiz in mode 11", out_hiz, 1);
    chk("R7", "code kept in mode 11", dac_code, 12'h555);
    frame(16'h0555, 16, 1, 1);
    chk("R7", "code on wake", dac_code, 12'h555);
    chk("R6", "power_down cleared", power_down, 0);

    // R5: extra edges, then a second burst with sync_n still low
    frame(16'h0800, 20, 0, 1);
    frame(16'h0123, 16, 1, 0);
    chk("R5", "no commit without sync_n fall", dac_code, 12'h800);
    frame(16'h4FED, 16, 1, 1);
    chk("R5", "commit after new sync_n fall", dac_code, 12'hFED);

    wait_n(8);
    chk("R8", "no pending commits", due_q.size(), 0);
    finish_run();
  end
endmodule